// File: doc/BRIEF.md
# Saturating Threshold Counter Field

This block is one 32-bit register field that counts events. Hardware raises an increment strobe or a decrement strobe; each strobe moves the count by a step. Per direction, a parameter chooses whether that step is a fixed constant or is taken from a hardware step input of configurable width. Software can read the field at any time and can overwrite it. Hardware has no path that loads a data value into the field.

Each direction has its own saturation limit. An increment stops at the upper limit and a decrement stops at the lower limit. A one-cycle overflow or underflow pulse reports every move that was clamped. Two level flags compare the current count against separate up and down thresholds. A status or interrupt stage outside the block can use them. Address decoding and interrupt generation are not part of this block.

Top module: `sat_thresh_counter`

## Requirements
- R1: After the active-low synchronous reset the field reads 0 and both overflow and underflow are low.
- R2: An increment strobe adds the increment step. In the default build the step is the 4-bit `inc_step_i`, zero-extended. A step of 0 leaves the field unchanged.
- R3: A decrement strobe subtracts the decrement step. In the default build this is the constant 2, and `dec_step_i` has no effect.
- R4: Upper saturation limit, 15 by default:
  - An increment whose result would exceed the limit leaves the field at the limit.
  - If the field already holds more than the limit, such an increment leaves it unchanged.
  - In either case overflow pulses.
- R5: Lower saturation limit, 5 by default:
  - A decrement whose result would fall below the limit leaves the field at the limit.
  - If the field already holds less than the limit, such a decrement leaves it unchanged.
  - In either case underflow pulses.
- R6: When both strobes are high in the same cycle, the net change (increment step minus decrement step) is applied once. Saturation is judged on that single result, and a net change of zero does nothing.
- R7: A software write loads `sw_wdata_i` and overrides any strobe in the same cycle. Overflow and underflow stay low for that cycle.
- R8: `inc_thr_o` is high exactly while the field is at or above the increment threshold, 10 by default.
- R9: `dec_thr_o` is high exactly while the field is at or below the decrement threshold, 10 by default.
- R10: Overflow and underflow are pulses that describe only the previous cycle's update. A cycle with no strobes is followed by both being low.
- R11: `sw_rdata_o` always shows the current field value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sw_we_i | input | 1 | Software write strobe |
| sw_wdata_i | input | 32 | Software write data |
| sw_rdata_o | output | 32 | Current field value |
| inc_i | input | 1 | Increment strobe |
| inc_step_i | input | 4 | Dynamic increment step |
| dec_i | input | 1 | Decrement strobe |
| dec_step_i | input | 4 | Dynamic decrement step (unused in default build) |
| inc_thr_o | output | 1 | Count at or above increment threshold |
| dec_thr_o | output | 1 | Count at or below decrement threshold |
| overflow_o | output | 1 | One-cycle pulse: last increment was clamped |
| underflow_o | output | 1 | One-cycle pulse: last decrement was clamped |

## Verification
A strobe or write that is held during one clock cycle changes the field and the overflow and underflow pulses at the next rising edge. It therefore becomes visible exactly one cycle later. The threshold flags are derived from the field with no further register, so they are due in that same cycle.

The driver tags every expected item with the cycle in which it is due. The monitor compares an item only in that cycle, sampling on the falling edge. A late or early result is therefore reported as a miscompare and does not slip through.

// File: rtl/stc_pkg.sv
// Package: shared types for the saturating threshold counter.
// Assumes nothing beyond IEEE 1800-2017 packed structs.
package stc_pkg;

    // Clamp indication produced by the next-value logic.
    typedef struct packed {
        logic over;
        logic under;
    } stc_wrap_t;

endpackage

// File: rtl/stc_step_sel.sv
// Module: stc_step_sel
// Turns one strobe into a step amount of counter width. The amount is 0
// when the strobe is low. DYN selects the zero-extended hardware step
// input instead of the constant step.
// Assumes IN_W <= CNT_W.
module stc_step_sel #(
    parameter int                 CNT_W      = 32,
    parameter int                 IN_W       = 4,
    parameter bit                 DYN        = 1'b0,
    parameter logic [CNT_W-1:0]   CONST_STEP = 1
) (
    input  logic                  strobe_i,
    input  logic [IN_W-1:0]       step_i,
    output logic [CNT_W-1:0]      amt_o
);

    logic [CNT_W-1:0] dyn_ext;
    logic [CNT_W-1:0] chosen;

    // Zero-extend the hardware step to counter width.
    assign dyn_ext = CNT_W'(step_i);

    // Parameter picks the step source.
    generate
        if (DYN) begin : g_dyn
            assign chosen = dyn_ext;
        end else begin : g_const
            assign chosen = CONST_STEP | (dyn_ext & '0);
        end
    endgenerate

    // Gate by the strobe.
    assign amt_o = strobe_i ? chosen : '0;

endmodule

// File: rtl/stc_next.sv
// Module: stc_next
// Computes the next count from the current count and the two step
// amounts. The net change is applied once. An upward move past UP_LIM
// clamps and flags over; a downward move past LO_LIM clamps and flags
// under. A count already beyond the limit in the direction of motion
// is held. Arithmetic uses two spare bits, so nothing wraps silently.
module stc_next
    import stc_pkg::*;
#(
    parameter int               CNT_W  = 32,
    parameter logic [CNT_W-1:0] UP_LIM = '1,
    parameter logic [CNT_W-1:0] LO_LIM = '0
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] inc_amt_i,
    input  logic [CNT_W-1:0] dec_amt_i,
    output logic [CNT_W-1:0] nxt_o,
    output stc_wrap_t        wrap_o
);

    localparam int EW = CNT_W + 2;

    logic signed [EW-1:0] raw;
    logic signed [EW-1:0] hi_lim;
    logic signed [EW-1:0] lo_lim;
    logic                 going_up;
    logic                 going_down;

    // Extended-width sum of the net change.
    assign raw = $signed({2'b00, cnt_i}) + $signed({2'b00, inc_amt_i})
               - $signed({2'b00, dec_amt_i});
    assign hi_lim     = $signed({2'b00, UP_LIM});
    assign lo_lim     = $signed({2'b00, LO_LIM});
    assign going_up   = inc_amt_i > dec_amt_i;
    assign going_down = dec_amt_i > inc_amt_i;

    // Saturation decision on the single net result.
    always_comb begin
        nxt_o        = raw[CNT_W-1:0];
        wrap_o.over  = 1'b0;
        wrap_o.under = 1'b0;
        if (going_up && (raw > hi_lim)) begin
            wrap_o.over = 1'b1;
            nxt_o       = (cnt_i > UP_LIM) ? cnt_i : UP_LIM;
        end else if (going_down && (raw < lo_lim)) begin
            wrap_o.under = 1'b1;
            nxt_o        = (cnt_i < LO_LIM) ? cnt_i : LO_LIM;
        end
    end

endmodule

// File: rtl/stc_flags.sv
// Module: stc_flags
// Level threshold flags, derived from the registered count with no
// further state.
module stc_flags #(
    parameter int               CNT_W  = 32,
    parameter logic [CNT_W-1:0] UP_THR = '0,
    parameter logic [CNT_W-1:0] DN_THR = '0
) (
    input  logic [CNT_W-1:0] cnt_i,
    output logic             up_thr_o,
    output logic             dn_thr_o
);

    // Compare the count against each threshold.
    assign up_thr_o = cnt_i >= UP_THR;
    assign dn_thr_o = cnt_i <= DN_THR;

endmodule

// File: rtl/sat_thresh_counter.sv
// Module: sat_thresh_counter (top)
// Software-read/write counter field with hardware increment and
// decrement strobes, per-direction saturation, threshold flags and
// clamp pulses. A software write wins over strobes in the same cycle.
// Assumes a single clock and a synchronous active-low reset.
module sat_thresh_counter
    import stc_pkg::*;
#(
    parameter int               CNT_W    = 32,
    parameter int               INC_W    = 4,
    parameter int               DEC_W    = 4,
    parameter bit               INC_DYN  = 1'b1,
    parameter bit               DEC_DYN  = 1'b0,
    parameter logic [CNT_W-1:0] INC_STEP = 2,
    parameter logic [CNT_W-1:0] DEC_STEP = 2,
    parameter logic [CNT_W-1:0] INC_SAT  = 15,
    parameter logic [CNT_W-1:0] DEC_SAT  = 5,
    parameter logic [CNT_W-1:0] INC_THR  = 10,
    parameter logic [CNT_W-1:0] DEC_THR  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_we_i,
    input  logic [CNT_W-1:0] sw_wdata_i,
    output logic [CNT_W-1:0] sw_rdata_o,
    input  logic             inc_i,
    input  logic [INC_W-1:0] inc_step_i,
    input  logic             dec_i,
    input  logic [DEC_W-1:0] dec_step_i,
    output logic             inc_thr_o,
    output logic             dec_thr_o,
    output logic             overflow_o,
    output logic             underflow_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] inc_amt;
    logic [CNT_W-1:0] dec_amt;
    logic [CNT_W-1:0] cnt_nxt;
    stc_wrap_t        wrap_nxt;
    stc_wrap_t        wrap_q;

    stc_step_sel #(
        .CNT_W(CNT_W), .IN_W(INC_W), .DYN(INC_DYN), .CONST_STEP(INC_STEP)
    ) u_inc_step (
        .strobe_i(inc_i), .step_i(inc_step_i), .amt_o(inc_amt)
    );

    stc_step_sel #(
        .CNT_W(CNT_W), .IN_W(DEC_W), .DYN(DEC_DYN), .CONST_STEP(DEC_STEP)
    ) u_dec_step (
        .strobe_i(dec_i), .step_i(dec_step_i), .amt_o(dec_amt)
    );

    stc_next #(
        .CNT_W(CNT_W), .UP_LIM(INC_SAT), .LO_LIM(DEC_SAT)
    ) u_next (
        .cnt_i(cnt_q), .inc_amt_i(inc_amt), .dec_amt_i(dec_amt),
        .nxt_o(cnt_nxt), .wrap_o(wrap_nxt)
    );

    stc_flags #(
        .CNT_W(CNT_W), .UP_THR(INC_THR), .DN_THR(DEC_THR)
    ) u_flags (
        .cnt_i(cnt_q), .up_thr_o(inc_thr_o), .dn_thr_o(dec_thr_o)
    );

    // Field register: reset, software write, or hardware update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (sw_we_i) begin
            cnt_q <= sw_wdata_i;
        end else begin
            cnt_q <= cnt_nxt;
        end
    end

    // Clamp pulses: one cycle, suppressed by a software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrap_q <= '0;
        end else if (sw_we_i) begin
            wrap_q <= '0;
        end else begin
            wrap_q <= wrap_nxt;
        end
    end

    assign sw_rdata_o  = cnt_q;
    assign overflow_o  = wrap_q.over;
    assign underflow_o = wrap_q.under;

endmodule

// File: rtl/stc_checker.sv
// Module: stc_checker
// Concurrent checks on the counter's ports, bound into every instance.
module stc_checker #(
    parameter int               CNT_W   = 32,
    parameter logic [CNT_W-1:0] INC_SAT = 15,
    parameter logic [CNT_W-1:0] DEC_SAT = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sw_we_i,
    input logic [CNT_W-1:0] sw_wdata_i,
    input logic [CNT_W-1:0] sw_rdata_o,
    input logic             inc_i,
    input logic             dec_i,
    input logic             overflow_o,
    input logic             underflow_o
);

    // R1: reset clears the field and the pulses.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (sw_rdata_o == '0) && !overflow_o && !underflow_o);

    // R4: once within the upper limit, hardware never carries the field above it.
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we_i && (sw_rdata_o <= INC_SAT)) |=> (sw_rdata_o <= INC_SAT));

    // R5: once at or above the lower limit, hardware never takes the field below it.
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we_i && (sw_rdata_o >= DEC_SAT)) |=> (sw_rdata_o >= DEC_SAT));

    // R7: a software write lands as written, with no pulses.
    p_sw_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we_i |=> (sw_rdata_o == $past(sw_wdata_i)) && !overflow_o && !underflow_o);

    // R10: a quiet cycle leaves the field unchanged and clears both pulses.
    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we_i && !inc_i && !dec_i) |=> $stable(sw_rdata_o) && !overflow_o && !underflow_o);

    // R10: the two pulses never fire together.
    p_pulse_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(overflow_o && underflow_o));

endmodule

bind sat_thresh_counter stc_checker #(
    .CNT_W(CNT_W), .INC_SAT(INC_SAT), .DEC_SAT(DEC_SAT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sw_we_i(sw_we_i), .sw_wdata_i(sw_wdata_i),
    .sw_rdata_o(sw_rdata_o), .inc_i(inc_i), .dec_i(dec_i),
    .overflow_o(overflow_o), .underflow_o(underflow_o)
);

// File: tb/sat_thresh_counter_tb.sv
// Scoreboard bench: the driver pushes expected items tagged with the
// cycle in which they are due; the monitor compares on the falling edge.
module sat_thresh_counter_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sw_we_i;
    logic [31:0] sw_wdata_i;
    logic [31:0] sw_rdata_o;
    logic        inc_i;
    logic [3:0]  inc_step_i;
    logic        dec_i;
    logic [3:0]  dec_step_i;
    logic        inc_thr_o;
    logic        dec_thr_o;
    logic        overflow_o;
    logic        underflow_o;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        int     due;
        longint cnt;
        bit     ov;
        bit     un;
        string  tag;
    } exp_t;

    exp_t   q[$];
    longint m_cnt;

    always #4 clk = ~clk;   // 125 MHz

    always @(posedge clk) cyc <= cyc + 1;

    sat_thresh_counter u_dut (
        .clk(clk), .rst_n(rst_n), .sw_we_i(sw_we_i), .sw_wdata_i(sw_wdata_i),
        .sw_rdata_o(sw_rdata_o), .inc_i(inc_i), .inc_step_i(inc_step_i),
        .dec_i(dec_i), .dec_step_i(dec_step_i), .inc_thr_o(inc_thr_o),
        .dec_thr_o(dec_thr_o), .overflow_o(overflow_o), .underflow_o(underflow_o)
    );

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Drive one cycle of stimulus and queue the expected result.
    // Model per requirements: inc step from inc_step_i, dec step 2,
    // limits 15/5, write wins.
    task automatic drive(input bit we, input longint wd, input bit inc,
                         input int istep, input bit dec, input int dstep,
                         input string tag);
        longint ia, da, raw;
        exp_t   e;
        @(negedge clk);
        sw_we_i    = we;
        sw_wdata_i = wd[31:0];
        inc_i      = inc;
        inc_step_i = istep[3:0];
        dec_i      = dec;
        dec_step_i = dstep[3:0];
        e.ov = 1'b0;
        e.un = 1'b0;
        if (we) begin
            m_cnt = wd;
        end else begin
            ia  = inc ? longint'(istep) : 0;
            da  = dec ? 2 : 0;
            raw = m_cnt + ia - da;
            if (ia > da && raw > 15) begin
                e.ov = 1'b1;
                if (m_cnt <= 15) m_cnt = 15;
            end else if (da > ia && raw < 5) begin
                e.un = 1'b1;
                if (m_cnt >= 5) m_cnt = 5;
            end else begin
                m_cnt = raw;
            end
        end
        e.cnt = m_cnt;
        e.due = cyc + 1;
        e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare every item in its due cycle.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            check(e.tag, "count", longint'(sw_rdata_o), e.cnt);
            check(e.tag, "overflow", longint'(overflow_o), longint'(e.ov));
            check(e.tag, "underflow", longint'(underflow_o), longint'(e.un));
            check({e.tag, "/R8"}, "inc_thr", longint'(inc_thr_o), longint'(e.cnt >= 10));
            check({e.tag, "/R9"}, "dec_thr", longint'(dec_thr_o), longint'(e.cnt <= 10));
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sw_we_i = 1'b0; sw_wdata_i = '0;
        inc_i = 1'b0; inc_step_i = '0; dec_i = 1'b0; dec_step_i = '0;
        m_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1", "count", longint'(sw_rdata_o), 0);
        check("R1", "overflow", longint'(overflow_o), 0);
        check("R1", "underflow", longint'(underflow_o), 0);

        drive(0, 0, 1, 3, 0, 0, "R2 inc 3");
        drive(0, 0, 1, 3, 0, 0, "R2 inc 3 again");
        drive(0, 0, 1, 4, 0, 0, "R2 reach thr 10");
        drive(0, 0, 1, 0, 0, 0, "R2 step zero");
        drive(0, 0, 1, 4, 0, 0, "R2 to 14");
        drive(0, 0, 1, 3, 0, 0, "R4 clamp 15");
        drive(0, 0, 0, 0, 0, 0, "R10 quiet after ov");
        drive(0, 0, 0, 0, 1, 9, "R3 dec const, dec_step ignored");
        drive(0, 0, 1, 1, 1, 0, "R6 net -1");
        drive(0, 0, 1, 5, 1, 0, "R6 net +3 to 15");
        drive(0, 0, 1, 2, 1, 0, "R6 net zero");
        drive(0, 0, 1, 9, 1, 0, "R6 net clamp ov");
        drive(1, 100, 1, 7, 0, 0, "R7 write wins");
        drive(0, 0, 1, 1, 0, 0, "R4 hold above limit");
        drive(0, 0, 0, 0, 1, 0, "R3 dec from 100");
        drive(1, 6, 0, 0, 1, 0, "R7 write wins over dec");
        drive(0, 0, 0, 0, 1, 0, "R5 clamp 5");
        drive(0, 0, 0, 0, 1, 0, "R5 stay at 5");
        drive(0, 0, 0, 0, 0, 0, "R10 quiet after un");
        drive(1, 2, 0, 0, 0, 0, "R11 write 2");
        drive(0, 0, 0, 0, 1, 0, "R5 hold below limit");
        drive(1, 64'hFFFF_FFFF, 0, 0, 0, 0, "R11 write max");
        drive(0, 0, 1, 15, 0, 0, "R4 hold at max");
        drive(0, 0, 0, 0, 1, 0, "R3 dec from max");
        drive(1, 10, 0, 0, 0, 0, "R8 R9 at 10");
        drive(0, 0, 1, 1, 0, 0, "R8 above thr");
        drive(0, 0, 0, 0, 1, 0, "R9 below thr");

        @(negedge clk);
        sw_we_i = 1'b0; inc_i = 1'b0; dec_i = 1'b0;
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule